// File: doc/BRIEF.md
# Edge-Counted Serial Result Shifter

This block is the device-side output stage of a serial converter readout. An external host toggles a serial clock line. The block counts the edges of that clock to decide which bit of a 16-bit frame to drive. Each frame is four zero bits followed by the 12-bit result, most significant bit first. The pad is reduced to a data bit plus an output-enable. The enable is low whenever the line would be high impedance.

Everything runs on one fast system clock. The serial clock, the active-low conversion strobe and the result-load strobe are all sampled on that clock. The serial clock and the conversion strobe are edge-detected.

A pulse on the load strobe copies the parallel result into a held output register. A falling edge of the conversion strobe resynchronises the frame to its start, but only while the serial clock is low. After the sixteenth falling serial edge the line is released. One more rising edge restarts the frame, and from then on the line stays driven until the next resynchronisation.

The sequencer has five named states:
- `ST_IDLE`: released, waiting for the first rising edge.
- `ST_LEAD`: driving the leading zeros.
- `ST_DATA`: driving result bits.
- `ST_DONE`: released after a complete frame.
- `ST_RERUN`: free-running repeat frames that never release.

Its transitions are:
- IDLE to LEAD on a rising edge.
- LEAD to DATA on the fourth falling edge.
- DATA to DONE on the sixteenth falling edge.
- DONE to RERUN on a rising edge.
- RERUN wraps to its own first bit on its sixteenth falling edge.
- Any state goes to IDLE on a resynchronisation.

Top module: `edge_frame_shifter`

## Requirements
- R1: After reset the output-enable `sd_oe` is 0 and `sd_o` is 0.
- R2: The first rising serial edge after reset or after a resynchronisation sets `sd_oe` to 1 and drives frame position 0, which is a zero.
- R3: Frame position p (0 to 15) drives bit 15-p of the word {4'b0000, held_result[11:0]}. Position 0 is taken at the first rising edge, and every falling edge advances the position by one.
- R4: On the sixteenth falling edge of a frame `sd_oe` drops to 0. The output-enable changes only on a serial edge or a resynchronisation.
- R5: A rising edge while released after a completed frame restarts the frame at position 0 and drives it. Afterwards the sixteenth falling edge of each repeated frame wraps back to position 0 and keeps `sd_oe` at 1.
- R6: A falling edge of `conv_n` while `sclk` is low releases the line (`sd_oe`=0) and returns the frame to its start.
- R7: A falling edge of `conv_n` while `sclk` is high has no effect: the frame position and output are kept.
- R8: `result_in` is captured only on a cycle with `load_stb`=1. Changes of `result_in` without the strobe do not alter the frame.
- R9: The serial clock may pause between edges, for example between two bytes. With no serial edge, no resynchronisation and no load, `sd_o` and `sd_oe` hold their values.
- R10: When a resynchronisation and a falling serial edge arrive in the same cycle, the resynchronisation wins and the line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host, sampled on `clk` |
| conv_n | input | 1 | Active-low conversion strobe; its falling edge resynchronises |
| load_stb | input | 1 | One-cycle pulse copying `result_in` into the held register |
| result_in | input | 12 | Parallel conversion result |
| sd_o | output | 1 | Serial data bit (0 while released) |
| sd_oe | output | 1 | Output-enable; 0 means the pad is high impedance |

## Verification
The resynchronisation and the serial-clock falling edge can fall in the same system-clock cycle. This happens when the host drops `sclk` at the moment `conv_n` falls. The bench provokes it by driving both lines low on the same half cycle, mid-way through the data bits of a result with many ones. It then judges two things: the line must be released, and the next rising edge must produce a leading zero rather than the next data bit. The test where `conv_n` falls while `sclk` is high is the opposite case. It must leave the position untouched, so the following falling edge continues with the next result bit.

// File: rtl/efs_pkg.sv
package efs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_DATA  = 3'd2,
        ST_DONE  = 3'd3,
        ST_RERUN = 3'd4
    } efs_state_e;

    function automatic logic is_driving(input efs_state_e s);
        return (s == ST_LEAD) || (s == ST_DATA) || (s == ST_RERUN);
    endfunction

endpackage

// File: rtl/efs_edge_detect.sv
module efs_edge_detect #(
    parameter int unsigned         N       = 3,
    parameter logic [N-1:0]        RISE_SEL = '0,
    parameter logic [N-1:0]        RST_LVL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] hit
);

    logic [N-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= RST_LVL;
        end else begin
            last_q <= din;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        if (RISE_SEL[i]) begin : g_rise
            assign hit[i] = din[i] & ~last_q[i];
        end else begin : g_fall
            assign hit[i] = ~din[i] & last_q[i];
        end
    end

endmodule

// File: rtl/efs_result_hold.sv
module efs_result_hold #(
    parameter int unsigned RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [RES_W-1:0] result_in,
    output logic [RES_W-1:0] held
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (load_stb) begin
            held <= result_in;
        end
    end

endmodule

// File: rtl/efs_frame_fsm.sv
module efs_frame_fsm
    import efs_pkg::*;
#(
    parameter int unsigned LEAD_N  = 4,
    parameter int unsigned FRAME_W = 16,
    localparam int unsigned CNT_W  = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             resync,
    output efs_state_e       state,
    output logic [CNT_W-1:0] pos
);

    localparam logic [CNT_W-1:0] POS_LAST      = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] POS_LEAD_LAST = CNT_W'(LEAD_N - 1);

    efs_state_e       state_n;
    logic [CNT_W-1:0] pos_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pos   <= '0;
        end else begin
            state <= state_n;
            pos   <= pos_n;
        end
    end

    always_comb begin
        state_n = state;
        pos_n   = pos;
        if (resync) begin
            state_n = ST_IDLE;
            pos_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (sclk_rise) begin
                        state_n = ST_LEAD;
                        pos_n   = '0;
                    end
                end
                ST_LEAD: begin
                    if (sclk_fall) begin
                        pos_n = pos + 1'b1;
                        if (pos == POS_LEAD_LAST) begin
                            state_n = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (sclk_fall) begin
                        if (pos == POS_LAST) begin
                            state_n = ST_DONE;
                            pos_n   = '0;
                        end else begin
                            pos_n = pos + 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    if (sclk_rise) begin
                        state_n = ST_RERUN;
                        pos_n   = '0;
                    end
                end
                ST_RERUN: begin
                    if (sclk_fall) begin
                        pos_n = (pos == POS_LAST) ? '0 : pos + 1'b1;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    pos_n   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/efs_bit_mux.sv
module efs_bit_mux
    import efs_pkg::*;
#(
    parameter int unsigned RES_W   = 12,
    parameter int unsigned LEAD_N  = 4,
    localparam int unsigned FRAME_W = RES_W + LEAD_N,
    localparam int unsigned CNT_W   = $clog2(FRAME_W)
) (
    input  efs_state_e       state,
    input  logic [CNT_W-1:0] pos,
    input  logic [RES_W-1:0] held,
    output logic             sd_o,
    output logic             sd_oe
);

    localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] frame_word;
    logic [CNT_W-1:0]   sel;

    assign frame_word = {{LEAD_N{1'b0}}, held};
    assign sel        = POS_LAST - pos;

    always_comb begin
        sd_oe = is_driving(state);
        unique case (state)
            ST_LEAD:           sd_o = 1'b0;
            ST_DATA, ST_RERUN: sd_o = frame_word[sel];
            default:           sd_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/edge_frame_shifter.sv
module edge_frame_shifter
    import efs_pkg::*;
#(
    parameter int unsigned RES_W  = 12,
    parameter int unsigned LEAD_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             conv_n,
    input  logic             load_stb,
    input  logic [RES_W-1:0] result_in,
    output logic             sd_o,
    output logic             sd_oe
);

    localparam int unsigned FRAME_W = RES_W + LEAD_N;
    localparam int unsigned CNT_W   = $clog2(FRAME_W);

    logic [2:0]       edge_hit;
    logic             sclk_fall;
    logic             sclk_rise;
    logic             conv_fall;
    logic             resync;
    logic [RES_W-1:0] held;
    efs_state_e       state;
    logic [CNT_W-1:0] pos;

    efs_edge_detect #(
        .N        (3),
        .RISE_SEL (3'b010),
        .RST_LVL  (3'b100)
    ) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({conv_n, sclk, sclk}),
        .hit   (edge_hit)
    );

    assign sclk_fall = edge_hit[0];
    assign sclk_rise = edge_hit[1];
    assign conv_fall = edge_hit[2];
    assign resync    = conv_fall & ~sclk;

    efs_result_hold #(
        .RES_W (RES_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_stb  (load_stb),
        .result_in (result_in),
        .held      (held)
    );

    efs_frame_fsm #(
        .LEAD_N  (LEAD_N),
        .FRAME_W (FRAME_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .resync    (resync),
        .state     (state),
        .pos       (pos)
    );

    efs_bit_mux #(
        .RES_W  (RES_W),
        .LEAD_N (LEAD_N)
    ) u_mux (
        .state (state),
        .pos   (pos),
        .held  (held),
        .sd_o  (sd_o),
        .sd_oe (sd_oe)
    );

endmodule

// File: rtl/efs_checker.sv
module efs_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic conv_n,
    input logic load_stb,
    input logic sd_o,
    input logic sd_oe
);

    logic sclk_q;
    logic conv_q;
    logic s_rise;
    logic s_fall;
    logic c_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            conv_q <= 1'b1;
        end else begin
            sclk_q <= sclk;
            conv_q <= conv_n;
        end
    end

    assign s_rise = sclk & ~sclk_q;
    assign s_fall = ~sclk & sclk_q;
    assign c_fall = ~conv_n & conv_q;

    AST_FIRST_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rise && !sd_oe) |=> (sd_oe && !sd_o)); // R2

    AST_RESYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_fall && !sclk) |=> !sd_oe); // R6

    AST_DRIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && !s_fall && !(c_fall && !sclk)) |=> sd_oe); // R4

    AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_oe && !s_rise) |=> !sd_oe); // R4

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_rise && !s_fall && !c_fall && !load_stb) |=> ($stable(sd_o) && $stable(sd_oe))); // R9

endmodule

bind edge_frame_shifter efs_checker u_efs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .conv_n   (conv_n),
    .load_stb (load_stb),
    .sd_o     (sd_o),
    .sd_oe    (sd_oe)
);

// File: tb/edge_frame_shifter_tb_top.sv
module edge_frame_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        conv_n = 1'b1;
    logic        load_stb = 1'b0;
    logic [11:0] result_in = '0;
    logic        sd_o;
    logic        sd_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    localparam int NPAT = 6;
    localparam logic [11:0] PATS [NPAT] = '{12'hA5C, 12'h000, 12'hFFF, 12'h801, 12'h001, 12'h5A3};

    always #2 clk = ~clk;

    edge_frame_shifter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .conv_n    (conv_n),
        .load_stb  (load_stb),
        .result_in (result_in),
        .sd_o      (sd_o),
        .sd_oe     (sd_oe)
    );

    task automatic chk(input string tag, input logic exp_oe, input logic exp_d);
        n_chk++;
        if (sd_oe !== exp_oe || (exp_oe && sd_o !== exp_d)) begin
            n_fail++;
            $display("FAIL %s: actual oe=%b d=%b expected oe=%b d=%b", tag, sd_oe, sd_o, exp_oe, exp_d);
        end
    endtask

    task automatic drive_sclk(input logic v);
        @(negedge clk) sclk = v;
        @(negedge clk);
    endtask

    task automatic pulse_resync();
        @(negedge clk) conv_n = 1'b0;
        @(negedge clk) conv_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_value(input logic [11:0] v);
        @(negedge clk) begin
            result_in = v;
            load_stb  = 1'b1;
        end
        @(negedge clk) load_stb = 1'b0;
    endtask

    task automatic read_frame(input logic [11:0] v, input string tag);
        logic [15:0] fw;
        fw = {4'b0000, v};
        for (int i = 0; i < 16; i++) begin
            drive_sclk(1'b1);
            chk(tag, 1'b1, fw[15-i]);
            drive_sclk(1'b0);
            if (i < 15) chk(tag, 1'b1, fw[14-i]);
            else        chk({tag, " release R4"}, 1'b0, 1'b0);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] fw;
        repeat (3) @(negedge clk);
        chk("R1 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b0, 1'b0);

        // Table walk: load, resynchronise, read a full frame (R2 R3 R4)
        for (int p = 0; p < NPAT; p++) begin
            load_value(PATS[p]);
            pulse_resync();
            chk("R6 resync", 1'b0, 1'b0);
            read_frame(PATS[p], "R3 frame");
        end

        // R8: result changes without the strobe are ignored
        load_value(12'h3C5);
        @(negedge clk) result_in = 12'hC3A;
        pulse_resync();
        read_frame(12'h3C5, "R8 no strobe");

        // R9: two bursts of eight with a pause
        load_value(12'h96B);
        pulse_resync();
        fw = {4'b0000, 12'h96B};
        for (int i = 0; i < 8; i++) begin
            drive_sclk(1'b1);
            drive_sclk(1'b0);
        end
        chk("R9 after byte", 1'b1, fw[7]);
        repeat (12) @(negedge clk);
        chk("R9 pause hold", 1'b1, fw[7]);
        for (int i = 8; i < 16; i++) begin
            drive_sclk(1'b1);
            chk("R9 second byte", 1'b1, fw[15-i]);
            drive_sclk(1'b0);
        end
        chk("R9 release R4", 1'b0, 1'b0);

        // R5: extra clocks restart and keep driving
        drive_sclk(1'b1);
        chk("R5 restart", 1'b1, 1'b0);
        drive_sclk(1'b0);
        chk("R5 rerun pos1", 1'b1, fw[14]);
        for (int i = 1; i < 16; i++) begin
            drive_sclk(1'b1);
            drive_sclk(1'b0);
        end
        chk("R5 wrap driven", 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        chk("R5 stays driven", 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            drive_sclk(1'b1);
            drive_sclk(1'b0);
        end
        chk("R5 rerun data", 1'b1, fw[11]);
        pulse_resync();
        chk("R6 resync after rerun", 1'b0, 1'b0);
        drive_sclk(1'b1);
        chk("R2 first bit", 1'b1, 1'b0);
        drive_sclk(1'b0);

        // R7: conv falls while sclk high, position kept
        load_value(12'hFFF);
        pulse_resync();
        for (int i = 0; i < 6; i++) begin
            drive_sclk(1'b1);
            drive_sclk(1'b0);
        end
        drive_sclk(1'b1);
        @(negedge clk) conv_n = 1'b0;
        @(negedge clk);
        chk("R7 ignored conv", 1'b1, 1'b1);
        conv_n = 1'b1;
        drive_sclk(1'b0);
        chk("R7 next bit", 1'b1, 1'b1);

        // R10: resync coincides with sclk falling edge
        load_value(12'hFFF);
        pulse_resync();
        for (int i = 0; i < 9; i++) begin
            drive_sclk(1'b1);
            drive_sclk(1'b0);
        end
        drive_sclk(1'b1);
        chk("R10 before", 1'b1, 1'b1);
        @(negedge clk) begin
            sclk   = 1'b0;
            conv_n = 1'b0;
        end
        @(negedge clk);
        chk("R10 resync wins", 1'b0, 1'b0);
        conv_n = 1'b1;
        drive_sclk(1'b1);
        chk("R10 restart zero", 1'b1, 1'b0);
        drive_sclk(1'b0);
        chk("R10 lead zero", 1'b1, 1'b0);

        // R1: reset mid-frame releases the line
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-frame", 1'b0, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule